// File: doc/BRIEF.md
# Polled Link Health Monitor with Recovery Sequencer

This block watches a serial link whose controller raises no interrupt when the link changes state. A heartbeat timer samples the link state at a fixed interval. An up or down event is reported only when the sample differs from the state stored from the previous poll. When the link comes up, the negotiated lane width and speed are captured from a status word. Both values are then kept, unchanged, until the next time the link comes up.

If a poll finds the link down while the PHY flags that it is being held in forced detect, polling stops and a recovery sequence begins at once. The sequencer issues a fixed series of PHY control writes through a valid/acknowledge write port. It then waits for the PHY to settle, writes ones to clear four sticky error flags, and writes the forced-detect control back to zero so the link can retrain. After a retrain wait it judges the attempt. The attempt passes only when forced detect is off, the overflow flag is clear, and the width and speed on the status bus equal the values stored before the failure. A pass resumes heartbeat polling one heartbeat later. A failure repeats the whole sequence one heartbeat later.

All waits are counted in milliseconds from a prescaler derived from the clock frequency parameter, so a simulation can shorten them.

Top module: `link_recovery_seq`

## Requirements
- R1: While reset is asserted, and right after it, the block reports the link down, raises no event, holds `wr_valid` low and has `in_recovery` low. After reset is released it polls without waiting a heartbeat. An assertion of reset during recovery abandons the sequence.
- R2: The link is sampled once per heartbeat. `evt_up` and `evt_down` are single-cycle pulses, never high together, raised only when the sampled state differs from the stored state.
- R3: On an up transition, `link_width` takes `phy_status[9:4]` and `link_speed` takes `phy_status[3:0]`. Both hold their value while the link stays up, while it is down, and through recovery.
- R4: A poll that finds the link down with `force_detect` high starts the first recovery write in the same cycle as `evt_down`. A down link without `force_detect` only keeps polling.
- R5: Recovery first writes, in order, address 0x06 data 0xE0, address 0x04 data 0x40, address 0x04 data 0x60, and address 0x06 data 0x60.
- R6: After the fourth PHY write, the sequencer waits SETTLE_MS. It then writes address 0x10 data 0x100, address 0x14 data 0x1, address 0x18 data 0x1 and address 0x1C data 0x1, and then releases forced detect by writing address 0x20 data 0x0.
- R7: `wr_valid` stays high with `wr_addr` and `wr_data` stable until `wr_ack`. Each acknowledge completes exactly one write, so one attempt makes nine writes.
- R8: RETRAIN_MS after the release write, the attempt is judged. It passes only when `force_detect` and `ovf_flag` are low and the width and speed fields match the stored values. A pass gives one `evt_recov_ok` pulse, and polling resumes one heartbeat later.
- R9: A failed attempt gives one `evt_recov_retry` pulse. The first PHY write of the next attempt starts one heartbeat later.
- R10: `in_recovery` is high from the first recovery write through the verdict and the retry wait. `wr_valid` is never high outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_active | input | 1 | Raw link-active status from the PHY |
| force_detect | input | 1 | PHY held in forced detect |
| ovf_flag | input | 1 | Sticky overflow error flag |
| phy_status | input | STAT_W | Status word; width in [9:4], speed in [3:0] |
| wr_valid | output | 1 | Write request toward the PHY register port |
| wr_addr | output | 8 | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted this cycle |
| link_is_up | output | 1 | Stored link state |
| link_width | output | WID_W | Width captured at the last up transition |
| link_speed | output | SPD_W | Speed captured at the last up transition |
| evt_up | output | 1 | Link-up event pulse |
| evt_down | output | 1 | Link-down event pulse |
| evt_recov_ok | output | 1 | Recovery attempt passed |
| evt_recov_retry | output | 1 | Recovery attempt failed, retry scheduled |
| in_recovery | output | 1 | Recovery sequence in progress |

## Verification
A poll result cannot fall on a fixed cycle, because polls run on a heartbeat that was started at reset. Each stimulus vector is therefore held for two heartbeats plus margin, and the bench counts event pulses over that window. It then compares the count, the stored state and the captured fields. The write log records the falling edge at which each write was acknowledged. From it the bench measures four gaps: from `evt_down` to the first write (due in the same cycle), across the settle wait, from the release write to the verdict (RETRAIN_MS plus a few register stages), and from a retry pulse to the next first write (one heartbeat plus one cycle). Each gap must fall in a window that starts at the nominal delay and allows only the fixed pipeline stages.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int STEP_IDX_W = 4;
  localparam int PHY_FIRST  = 0;
  localparam int PHY_LAST   = 3;
  localparam int CLR_FIRST  = 4;
  localparam int CLR_LAST   = 8;

  typedef enum logic [2:0] {
    S_POLL,
    S_WAIT_HB,
    S_PHY,
    S_SETTLE,
    S_CLEAR,
    S_RETRAIN,
    S_VERIFY,
    S_RETRY
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } phy_wr_t;

  // Ordered recovery program: PHY lane kick, error clears, forced-detect release.
  function automatic phy_wr_t step_write(input logic [STEP_IDX_W-1:0] idx);
    phy_wr_t w;
    unique case (idx)
      4'd0:    begin w.addr = 8'h06; w.data = 32'h0000_00E0; end
      4'd1:    begin w.addr = 8'h04; w.data = 32'h0000_0040; end
      4'd2:    begin w.addr = 8'h04; w.data = 32'h0000_0060; end
      4'd3:    begin w.addr = 8'h06; w.data = 32'h0000_0060; end
      4'd4:    begin w.addr = 8'h10; w.data = 32'h0000_0100; end
      4'd5:    begin w.addr = 8'h14; w.data = 32'h0000_0001; end
      4'd6:    begin w.addr = 8'h18; w.data = 32'h0000_0001; end
      4'd7:    begin w.addr = 8'h1C; w.data = 32'h0000_0001; end
      4'd8:    begin w.addr = 8'h20; w.data = 32'h0000_0000; end
      default: begin w.addr = '0;    w.data = '0;            end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lhm_rst_sync.sv
module lhm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lhm_ms_timer.sv
module lhm_ms_timer #(
  parameter int CYC_PER_MS = 250000,
  parameter int MS_W       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] load_ms,
  output logic            expired
);

  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

  logic             busy_q, busy_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             exp_q, exp_d;

  always_comb begin
    busy_d = busy_q;
    pre_d  = pre_q;
    ms_d   = ms_q;
    exp_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      pre_d  = PRE_TOP;
      ms_d   = load_ms - 1'b1;
    end else if (busy_q) begin
      if (pre_q == '0) begin
        if (ms_q == '0) begin
          busy_d = 1'b0;
          exp_d  = 1'b1;
        end else begin
          ms_d  = ms_q - 1'b1;
          pre_d = PRE_TOP;
        end
      end else begin
        pre_d = pre_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      ms_q   <= '0;
      exp_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      ms_q   <= ms_d;
      exp_q  <= exp_d;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/lhm_wr_seq.sv
module lhm_wr_seq (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [lhm_pkg::STEP_IDX_W-1:0] first_idx,
  input  logic [lhm_pkg::STEP_IDX_W-1:0] last_idx,
  input  logic                           wr_ack,
  output logic                           wr_valid,
  output logic [lhm_pkg::ADDR_W-1:0]     wr_addr,
  output logic [lhm_pkg::DATA_W-1:0]     wr_data,
  output logic                           done
);

  logic                           busy_q, busy_d;
  logic [lhm_pkg::STEP_IDX_W-1:0] idx_q, idx_d;
  logic [lhm_pkg::STEP_IDX_W-1:0] last_q, last_d;
  logic                           done_q, done_d;
  lhm_pkg::phy_wr_t               cur;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    last_d = last_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = first_idx;
      last_d = last_idx;
    end else if (busy_q && wr_ack) begin
      if (idx_q == last_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  assign cur      = lhm_pkg::step_write(idx_q);
  assign wr_valid = busy_q;
  assign wr_addr  = cur.addr;
  assign wr_data  = cur.data;
  assign done     = done_q;

endmodule

// File: rtl/lhm_link_track.sv
module lhm_link_track #(
  parameter int STAT_W  = 16,
  parameter int WID_LSB = 4,
  parameter int WID_W   = 6,
  parameter int SPD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              link_active,
  input  logic [STAT_W-1:0] phy_status,
  output logic              link_is_up,
  output logic [WID_W-1:0]  link_width,
  output logic [SPD_W-1:0]  link_speed,
  output logic              evt_up,
  output logic              evt_down,
  output logic              fields_match
);

  logic             up_q, up_d;
  logic [WID_W-1:0] wid_q, wid_d;
  logic [SPD_W-1:0] spd_q, spd_d;
  logic             eu_q, eu_d, ed_q, ed_d;
  logic [WID_W-1:0] wid_now;
  logic [SPD_W-1:0] spd_now;
  logic             status_unused;

  assign wid_now       = phy_status[WID_LSB +: WID_W];
  assign spd_now       = phy_status[SPD_W-1:0];
  assign status_unused = ^phy_status;

  always_comb begin
    up_d  = up_q;
    wid_d = wid_q;
    spd_d = spd_q;
    eu_d  = 1'b0;
    ed_d  = 1'b0;
    if (sample && (link_active != up_q)) begin
      up_d = link_active;
      if (link_active) begin
        eu_d  = 1'b1;
        wid_d = wid_now;
        spd_d = spd_now;
      end else begin
        ed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      wid_q <= '0;
      spd_q <= '0;
      eu_q  <= 1'b0;
      ed_q  <= 1'b0;
    end else begin
      up_q  <= up_d;
      wid_q <= wid_d;
      spd_q <= spd_d;
      eu_q  <= eu_d;
      ed_q  <= ed_d;
    end
  end

  assign link_is_up   = up_q;
  assign link_width   = wid_q;
  assign link_speed   = spd_q;
  assign evt_up       = eu_q;
  assign evt_down     = ed_q;
  assign fields_match = (wid_now == wid_q) && (spd_now == spd_q);

endmodule

// File: rtl/link_recovery_seq.sv
module link_recovery_seq #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int HB_MS      = 1000,
  parameter int SETTLE_MS  = 100,
  parameter int RETRAIN_MS = 500,
  parameter int STAT_W     = 16,
  parameter int WID_LSB    = 4,
  parameter int WID_W      = 6,
  parameter int SPD_W      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       link_active,
  input  logic                       force_detect,
  input  logic                       ovf_flag,
  input  logic [STAT_W-1:0]          phy_status,
  output logic                       wr_valid,
  output logic [lhm_pkg::ADDR_W-1:0] wr_addr,
  output logic [lhm_pkg::DATA_W-1:0] wr_data,
  input  logic                       wr_ack,
  output logic                       link_is_up,
  output logic [WID_W-1:0]           link_width,
  output logic [SPD_W-1:0]           link_speed,
  output logic                       evt_up,
  output logic                       evt_down,
  output logic                       evt_recov_ok,
  output logic                       evt_recov_retry,
  output logic                       in_recovery
);

  import lhm_pkg::*;

  localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int MAX_A      = (HB_MS > SETTLE_MS) ? HB_MS : SETTLE_MS;
  localparam int MAX_MS     = (MAX_A > RETRAIN_MS) ? MAX_A : RETRAIN_MS;
  localparam int MS_W       = $clog2(MAX_MS + 1);
  localparam logic [MS_W-1:0] HB_LD      = MS_W'(HB_MS);
  localparam logic [MS_W-1:0] SETTLE_LD  = MS_W'(SETTLE_MS);
  localparam logic [MS_W-1:0] RETRAIN_LD = MS_W'(RETRAIN_MS);

  logic                  rst_n_int;
  seq_state_t            state_q, state_d;
  logic                  tmr_start, tmr_expired;
  logic [MS_W-1:0]       tmr_ms;
  logic                  seq_start, seq_done;
  logic [STEP_IDX_W-1:0] seq_first, seq_last;
  logic                  poll;
  logic                  fields_match;
  logic                  ok_d, ok_q, retry_d, retry_q;

  lhm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lhm_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (tmr_start),
    .load_ms (tmr_ms),
    .expired (tmr_expired)
  );

  lhm_wr_seq u_wr_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (seq_start),
    .first_idx (seq_first),
    .last_idx  (seq_last),
    .wr_ack    (wr_ack),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (seq_done)
  );

  lhm_link_track #(
    .STAT_W (STAT_W), .WID_LSB (WID_LSB), .WID_W (WID_W), .SPD_W (SPD_W)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .sample       (poll),
    .link_active  (link_active),
    .phy_status   (phy_status),
    .link_is_up   (link_is_up),
    .link_width   (link_width),
    .link_speed   (link_speed),
    .evt_up       (evt_up),
    .evt_down     (evt_down),
    .fields_match (fields_match)
  );

  // Next-state and control decode.
  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    tmr_ms    = HB_LD;
    seq_start = 1'b0;
    seq_first = STEP_IDX_W'(PHY_FIRST);
    seq_last  = STEP_IDX_W'(PHY_LAST);
    poll      = 1'b0;
    ok_d      = 1'b0;
    retry_d   = 1'b0;
    unique case (state_q)
      S_POLL: begin
        poll = 1'b1;
        if (!link_active && force_detect) begin
          seq_start = 1'b1;
          state_d   = S_PHY;
        end else begin
          tmr_start = 1'b1;
          state_d   = S_WAIT_HB;
        end
      end
      S_WAIT_HB: begin
        if (tmr_expired) state_d = S_POLL;
      end
      S_PHY: begin
        if (seq_done) begin
          tmr_start = 1'b1;
          tmr_ms    = SETTLE_LD;
          state_d   = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (tmr_expired) begin
          seq_start = 1'b1;
          seq_first = STEP_IDX_W'(CLR_FIRST);
          seq_last  = STEP_IDX_W'(CLR_LAST);
          state_d   = S_CLEAR;
        end
      end
      S_CLEAR: begin
        if (seq_done) begin
          tmr_start = 1'b1;
          tmr_ms    = RETRAIN_LD;
          state_d   = S_RETRAIN;
        end
      end
      S_RETRAIN: begin
        if (tmr_expired) state_d = S_VERIFY;
      end
      S_VERIFY: begin
        tmr_start = 1'b1;
        if (!force_detect && !ovf_flag && fields_match) begin
          ok_d    = 1'b1;
          state_d = S_WAIT_HB;
        end else begin
          retry_d = 1'b1;
          state_d = S_RETRY;
        end
      end
      S_RETRY: begin
        if (tmr_expired) begin
          seq_start = 1'b1;
          state_d   = S_PHY;
        end
      end
      default: state_d = S_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= S_POLL;
      ok_q    <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      retry_q <= retry_d;
    end
  end

  assign evt_recov_ok    = ok_q;
  assign evt_recov_retry = retry_q;
  assign in_recovery     = (state_q != S_POLL) && (state_q != S_WAIT_HB);

endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
  parameter int WID_W = 6,
  parameter int SPD_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_valid,
  input logic                       wr_ack,
  input logic [lhm_pkg::ADDR_W-1:0] wr_addr,
  input logic [lhm_pkg::DATA_W-1:0] wr_data,
  input logic                       link_is_up,
  input logic [WID_W-1:0]           link_width,
  input logic [SPD_W-1:0]           link_speed,
  input logic                       evt_up,
  input logic                       evt_down,
  input logic                       evt_recov_ok,
  input logic                       evt_recov_retry,
  input logic                       in_recovery
);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R2
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_up && evt_down));

  // R2
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_up || evt_down) |=> !(evt_up || evt_down));

  // R3
  up_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_up |-> link_is_up);

  // R3
  down_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_down |-> !link_is_up);

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_up |-> ($stable(link_width) && $stable(link_speed)));

  // R10
  wr_in_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> in_recovery);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_recov_ok, evt_recov_retry}));

  // R9
  verdict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_recov_ok || evt_recov_retry) |-> $past(in_recovery));

endmodule

bind link_recovery_seq lhm_checker #(.WID_W(WID_W), .SPD_W(SPD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_valid        (wr_valid),
  .wr_ack          (wr_ack),
  .wr_addr         (wr_addr),
  .wr_data         (wr_data),
  .link_is_up      (link_is_up),
  .link_width      (link_width),
  .link_speed      (link_speed),
  .evt_up          (evt_up),
  .evt_down        (evt_down),
  .evt_recov_ok    (evt_recov_ok),
  .evt_recov_retry (evt_recov_retry),
  .in_recovery     (in_recovery)
);

// File: tb/link_recovery_seq_bench.sv
module link_recovery_seq_bench;

  localparam int CLK_HZ      = 4000;
  localparam int HB_MS       = 5;
  localparam int SETTLE_MS   = 3;
  localparam int RETRAIN_MS  = 4;
  localparam int CPM         = CLK_HZ / 1000;
  localparam int HB_CYC      = HB_MS * CPM;
  localparam int SETTLE_CYC  = SETTLE_MS * CPM;
  localparam int RETRAIN_CYC = RETRAIN_MS * CPM;
  localparam int WIN         = 2 * HB_CYC + 10;
  localparam int WATCHDOG    = 100000;

  typedef struct packed {
    logic       act;
    logic [5:0] w;
    logic [3:0] s;
    logic [1:0] n_up;
    logic [1:0] n_dn;
    logic       exp_up;
    logic [5:0] exp_w;
    logic [3:0] exp_s;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 6'd8,  4'd3, 2'd1, 2'd0, 1'b1, 6'd8,  4'd3},
    '{1'b1, 6'd4,  4'd2, 2'd0, 2'd0, 1'b1, 6'd8,  4'd3},
    '{1'b0, 6'd4,  4'd2, 2'd0, 2'd1, 1'b0, 6'd8,  4'd3},
    '{1'b0, 6'd4,  4'd2, 2'd0, 2'd0, 1'b0, 6'd8,  4'd3},
    '{1'b1, 6'd16, 4'd1, 2'd1, 2'd0, 1'b1, 6'd16, 4'd1}
  };

  localparam logic [7:0]  EXP_ADDR [9] = '{8'h06, 8'h04, 8'h04, 8'h06, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};
  localparam logic [31:0] EXP_DATA [9] = '{32'hE0, 32'h40, 32'h60, 32'h60, 32'h100, 32'h1, 32'h1, 32'h1, 32'h0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_active, force_detect, ovf_flag, wr_ack;
  logic [15:0] phy_status;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        link_is_up;
  logic [5:0]  link_width;
  logic [3:0]  link_speed;
  logic        evt_up, evt_down, evt_recov_ok, evt_recov_retry, in_recovery;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, n_up = 0, n_dn = 0, n_ok = 0, n_retry = 0, n_wr = 0, n_rel = 0;
  int dn_cyc = 0, ok_cyc = 0, retry_cyc = 0;
  logic [7:0]  log_addr [64];
  logic [31:0] log_data [64];
  int          log_cyc  [64];
  int u0, d0, w0, r0, v0, k0, base;

  always #2 clk = ~clk;

  link_recovery_seq #(
    .CLK_HZ(CLK_HZ), .HB_MS(HB_MS), .SETTLE_MS(SETTLE_MS), .RETRAIN_MS(RETRAIN_MS)
  ) u_link_recovery_seq (
    .clk(clk), .rst_n(rst_n), .link_active(link_active), .force_detect(force_detect),
    .ovf_flag(ovf_flag), .phy_status(phy_status), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .link_is_up(link_is_up), .link_width(link_width),
    .link_speed(link_speed), .evt_up(evt_up), .evt_down(evt_down),
    .evt_recov_ok(evt_recov_ok), .evt_recov_retry(evt_recov_retry), .in_recovery(in_recovery)
  );

  function automatic logic [15:0] stat(input int w, input int s);
    return 16'(((w & 63) << 4) | (s & 15));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // which: 0 writes, 1 releases, 2 verdicts
  task automatic wait_ge(input int which, input int target, input string req);
    int cur;
    for (int t = 0; t < 2000; t++) begin
      cur = (which == 0) ? n_wr : (which == 1) ? n_rel : (n_ok + n_retry);
      if (cur >= target) return;
      tick();
    end
    chk(req, 0, 1);
  endtask

  // PHY port model, event monitor and watchdog.
  initial begin
    wr_ack = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (evt_up) n_up++;
      if (evt_down) begin n_dn++; dn_cyc = cyc; end
      if (evt_recov_ok) begin n_ok++; ok_cyc = cyc; end
      if (evt_recov_retry) begin n_retry++; retry_cyc = cyc; end
      if (wr_valid && !wr_ack) begin
        wr_ack = 1'b1;
        if (n_wr < 64) begin
          log_addr[n_wr] = wr_addr;
          log_data[n_wr] = wr_data;
          log_cyc[n_wr]  = cyc;
        end
        n_wr++;
        if (wr_addr == 8'h20) n_rel++;
      end else begin
        wr_ack = 1'b0;
      end
      if (cyc > WATCHDOG) begin
        n_fail++;
        $display("FAIL watchdog R1..R10 actual=%0d expected<=%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; link_active = 1'b0; force_detect = 1'b0; ovf_flag = 1'b0;
    phy_status = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 wr_valid in reset", int'(wr_valid), 0);
    chk("R1 link_is_up in reset", int'(link_is_up), 0);
    chk("R1 in_recovery in reset", int'(in_recovery), 0);
    chk("R1 events in reset", int'({evt_up, evt_down, evt_recov_ok, evt_recov_retry}), 0);
    rst_n = 1'b1;

    // Table: polling, edge detection, field capture (R2, R3, R4)
    for (int i = 0; i < 5; i++) begin
      u0 = n_up; d0 = n_dn; w0 = n_wr;
      link_active = VECS[i].act;
      phy_status  = stat(int'(VECS[i].w), int'(VECS[i].s));
      repeat (WIN) tick();
      chk($sformatf("R2 up events vec%0d", i), n_up - u0, int'(VECS[i].n_up));
      chk($sformatf("R2 down events vec%0d", i), n_dn - d0, int'(VECS[i].n_dn));
      chk($sformatf("R2 link state vec%0d", i), int'(link_is_up), int'(VECS[i].exp_up));
      chk($sformatf("R3 width vec%0d", i), int'(link_width), int'(VECS[i].exp_w));
      chk($sformatf("R3 speed vec%0d", i), int'(link_speed), int'(VECS[i].exp_s));
      chk($sformatf("R4 no writes without force_detect vec%0d", i), n_wr - w0, 0);
    end

    // Single recovery that passes (R4..R8, R10)
    base = n_wr; d0 = n_dn; r0 = n_rel; v0 = n_ok + n_retry; k0 = n_ok;
    phy_status = stat(16, 1);
    link_active = 1'b0; force_detect = 1'b1;
    wait_ge(1, r0 + 1, "R6 release write timeout");
    tick();
    chk("R10 in_recovery during retrain", int'(in_recovery), 1);
    force_detect = 1'b0;
    for (int j = 0; j < 9; j++) begin
      chk($sformatf("R5 R6 write %0d addr", j), int'(log_addr[base + j]), int'(EXP_ADDR[j]));
      chk($sformatf("R5 R6 write %0d data", j), int'(log_data[base + j]), int'(EXP_DATA[j]));
    end
    chk("R4 one down event", n_dn - d0, 1);
    chk_rng("R4 first write with down event", log_cyc[base] - dn_cyc, 0, 2);
    chk_rng("R6 settle gap", log_cyc[base + 4] - log_cyc[base + 3], SETTLE_CYC, SETTLE_CYC + 8);
    wait_ge(2, v0 + 1, "R8 verdict timeout");
    tick();
    chk("R8 pass verdict", n_ok - k0, 1);
    chk("R7 nine writes per attempt", n_wr - base, 9);
    chk_rng("R8 retrain gap", ok_cyc - log_cyc[base + 8], RETRAIN_CYC, RETRAIN_CYC + 8);
    chk("R10 in_recovery after pass", int'(in_recovery), 0);
    chk("R3 width held through recovery", int'(link_width), 16);
    u0 = n_up; w0 = n_wr;
    link_active = 1'b1;
    repeat (WIN) tick();
    chk("R8 polling resumes, up event", n_up - u0, 1);
    chk("R8 no writes after pass", n_wr - w0, 0);

    // Retries: width, speed, overflow, stuck forced detect, then pass (R8, R9)
    link_active = 1'b0; force_detect = 1'b1;
    for (int a = 0; a < 5; a++) begin
      r0 = n_rel; v0 = n_ok + n_retry; k0 = n_ok;
      phy_status = (a == 0) ? stat(4, 1) : (a == 1) ? stat(16, 2) : stat(16, 1);
      ovf_flag   = (a == 2);
      wait_ge(1, r0 + 1, "R9 release write timeout");
      tick();
      force_detect = (a == 3);
      wait_ge(2, v0 + 1, "R9 verdict timeout");
      tick();
      chk($sformatf("R8 R9 verdict attempt%0d", a), n_ok - k0, (a == 4) ? 1 : 0);
      chk($sformatf("R3 width held attempt%0d", a), int'(link_width), 16);
      if (a < 4) begin
        w0 = n_wr;
        wait_ge(0, w0 + 1, "R9 retry write timeout");
        chk_rng($sformatf("R9 retry gap attempt%0d", a), log_cyc[w0] - retry_cyc, HB_CYC, HB_CYC + 6);
        chk($sformatf("R9 retry restarts program attempt%0d", a), int'(log_addr[w0]), 8'h06);
        force_detect = 1'b1;
      end
    end
    link_active = 1'b1;
    repeat (WIN) tick();
    chk("R8 link back up after retries", int'(link_is_up), 1);

    // Reset during recovery (R1)
    w0 = n_wr;
    link_active = 1'b0; force_detect = 1'b1;
    wait_ge(0, w0 + 1, "R1 recovery start timeout");
    rst_n = 1'b0;
    #1;
    chk("R1 reset drops wr_valid", int'(wr_valid), 0);
    chk("R1 reset clears in_recovery", int'(in_recovery), 0);
    chk("R1 reset clears link state", int'(link_is_up), 0);
    repeat (3) tick();
    force_detect = 1'b0; link_active = 1'b1; phy_status = stat(8, 2);
    u0 = n_up; w0 = n_wr;
    rst_n = 1'b1;
    repeat (8) tick();
    chk("R1 immediate poll after reset", n_up - u0, 1);
    chk("R1 no writes after reset", n_wr - w0, 0);
    chk("R3 width after reset poll", int'(link_width), 8);
    chk("R3 speed after reset poll", int'(link_speed), 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule